// File: doc/BRIEF.md
# USB Line Termination Controller

This block drives the enables of the resistors that terminate the D+ and D- lines of a full-speed USB port. It follows the port's current role and the VBUS session state. In peripheral role it signals a full-speed attach by enabling the D+ pull-up, but only while the B-session is valid and software has not requested a disconnect. In host role it enables the pull-downs on both lines and no pull-up. The analog resistors and the role negotiation protocol sit outside the block. The block receives the negotiated role as two inputs and returns four resistor enables.

The D+ pull-up is built from two segments with separate enables, so the attach strength can be trimmed. When the pull-up comes on, both segments are enabled for a fixed settle period. After that, only the segments selected by a 2-bit strength input stay on.

Every change of the requested role goes through a programmable blanking gap with all terminations off, so a pull-up and a pull-down are never enabled together. The session input arrives asynchronously and is resynchronised before use. The outputs are registered.

Top module: `usb_term_ctrl`

## Requirements
- R1: While reset is high, and afterwards for as long as `role_valid_i` is low (no role given), all four resistor enables are 0.
- R2: In peripheral role, the pull-down enables are 0, and a D+ pull-up segment is enabled only while the synchronised session-valid signal is 1 and `soft_disc_i` is 0.
- R3: In host role, `dp_pd_o` and `dm_pd_o` are 1 and both pull-up enables are 0. Neither `bsess_valid_i` nor `soft_disc_i` changes these outputs. The role is host when `role_host_i`=1 and peripheral when `role_host_i`=0, and in both cases `role_valid_i` is 1.
- R4: The requested role changes at a sampling clock edge. That edge still outputs the old role's terminations. The outputs are then all 0 for exactly `gap_cycles_i`+1 cycles, and the new role's terminations appear on the following edge.
- R5: A pull-up enable and a pull-down enable are never 1 in the same cycle.
- R6: Each time the peripheral pull-up becomes wanted, both segments are on for exactly SETTLE_CYCLES cycles.
- R7: After the settle period, `dp_pu_a_o` equals `pu_strength_i[0]` and `dp_pu_b_o` equals `pu_strength_i[1]`. A strength change takes effect at the next clock edge.
- R8: `bsess_valid_i` passes through two flip-flops. When it falls, the pull-up enables are 0 from the third clock edge onward. When it rises, the settle sequence starts on the third edge.
- R9: When `soft_disc_i` is 1, the pull-up enables are 0 from the next clock edge. When it returns to 0, the settle sequence of R6 restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_valid_i | input | 1 | A role has been given |
| role_host_i | input | 1 | 1 = host role, 0 = peripheral role |
| bsess_valid_i | input | 1 | Asynchronous B-session valid |
| soft_disc_i | input | 1 | Forces the peripheral pull-up off |
| pu_strength_i | input | 2 | Segment select after settle (bit0 = A, bit1 = B) |
| gap_cycles_i | input | GAP_W | Blanking gap length on a role change |
| dp_pu_a_o | output | 1 | D+ pull-up segment A enable |
| dp_pu_b_o | output | 1 | D+ pull-up segment B enable |
| dp_pd_o | output | 1 | D+ pull-down enable |
| dm_pd_o | output | 1 | D- pull-down enable |

## Verification
The assertions check five behaviours on every cycle:
- pull-up and pull-down never overlap;
- the host outputs follow the applied host role;
- the pull-up drops after the synchronised session falls or a soft disconnect is requested;
- the applied role never moves directly from one active role to the other;
- the settle period starts with both segments on.

Only the bench scenarios can show the exact timing. These cover the blanking length for each gap value, the settle length, the strength encoding of every code, and the three-edge latency of session loss and return. The bench sweeps gap values and all strength codes in peripheral role. It also exercises host role, switching between roles, session toggling and soft disconnect.

// File: rtl/usb_term_pkg.sv
package usb_term_pkg;

    typedef enum logic [1:0] {
        ROLE_NONE   = 2'd0,
        ROLE_PERIPH = 2'd1,
        ROLE_HOST   = 2'd2
    } role_e;

    typedef struct packed {
        logic pu_seg_a;
        logic pu_seg_b;
        logic pd_dp;
        logic pd_dm;
    } term_t;

    localparam term_t TERM_OFF = '0;

    function automatic role_e decode_role(input logic valid, input logic host);
        if (!valid) begin
            return ROLE_NONE;
        end
        return host ? ROLE_HOST : ROLE_PERIPH;
    endfunction

    function automatic term_t build_term(input role_e role, input logic [1:0] seg);
        term_t t;
        t = TERM_OFF;
        case (role)
            ROLE_PERIPH: begin
                t.pu_seg_a = seg[0];
                t.pu_seg_b = seg[1];
            end
            ROLE_HOST: begin
                t.pd_dp = 1'b1;
                t.pd_dm = 1'b1;
            end
            default: ;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/usb_term_sync.sv
module usb_term_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/usb_term_role_seq.sv
module usb_term_role_seq
    import usb_term_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  role_e            req_role_i,
    input  logic [GAP_W-1:0] gap_cycles_i,
    output role_e            applied_o
);
    role_e            target_q;
    role_e            applied_q;
    logic [GAP_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q  <= ROLE_NONE;
            applied_q <= ROLE_NONE;
            cnt_q     <= '0;
            busy_q    <= 1'b0;
        end else if (req_role_i != target_q) begin
            target_q  <= req_role_i;
            applied_q <= ROLE_NONE;
            cnt_q     <= gap_cycles_i;
            busy_q    <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                applied_q <= target_q;
                busy_q    <= 1'b0;
            end else begin
                cnt_q <= cnt_q - GAP_W'(1);
            end
        end
    end

    assign applied_o = applied_q;

    AST_GAP_BREAK: assert property (@(posedge clk) disable iff (rst)
        (applied_q != ROLE_NONE) && ($past(applied_q) != ROLE_NONE)
            |-> applied_q == $past(applied_q)); // R4
endmodule

// File: rtl/usb_term_trim.sv
module usb_term_trim #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       want_i,
    input  logic [1:0] strength_i,
    output logic [1:0] seg_o
);
    localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !want_i) begin
            cnt_q <= SETTLE_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        if (!want_i) begin
            seg_o = 2'b00;
        end else if (cnt_q != '0) begin
            seg_o = 2'b11;
        end else begin
            seg_o = strength_i;
        end
    end

    if (SETTLE_CYCLES > 0) begin : g_settle_chk
        AST_SETTLE_FULL: assert property (@(posedge clk) disable iff (rst)
            $rose(want_i) |-> seg_o == 2'b11); // R6
    end
endmodule

// File: rtl/usb_term_ctrl.sv
module usb_term_ctrl
    import usb_term_pkg::*;
#(
    parameter int GAP_W         = 8,
    parameter int SETTLE_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             role_valid_i,
    input  logic             role_host_i,
    input  logic             bsess_valid_i,
    input  logic             soft_disc_i,
    input  logic [1:0]       pu_strength_i,
    input  logic [GAP_W-1:0] gap_cycles_i,
    output logic             dp_pu_a_o,
    output logic             dp_pu_b_o,
    output logic             dp_pd_o,
    output logic             dm_pd_o
);
    role_e      req_role;
    role_e      applied_role;
    logic       sess_s;
    logic       pu_want;
    logic [1:0] seg;
    term_t      term_d;
    term_t      term_q;

    assign req_role = decode_role(role_valid_i, role_host_i);

    usb_term_sync #(.STAGES(SYNC_STAGES)) u_sess_sync (
        .clk (clk),
        .rst (rst),
        .d_i (bsess_valid_i),
        .q_o (sess_s)
    );

    usb_term_role_seq #(.GAP_W(GAP_W)) u_role_seq (
        .clk          (clk),
        .rst          (rst),
        .req_role_i   (req_role),
        .gap_cycles_i (gap_cycles_i),
        .applied_o    (applied_role)
    );

    assign pu_want = (applied_role == ROLE_PERIPH) && sess_s && !soft_disc_i;

    usb_term_trim #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_trim (
        .clk        (clk),
        .rst        (rst),
        .want_i     (pu_want),
        .strength_i (pu_strength_i),
        .seg_o      (seg)
    );

    assign term_d = build_term(applied_role, seg);

    always_ff @(posedge clk) begin
        if (rst) begin
            term_q <= TERM_OFF;
        end else begin
            term_q <= term_d;
        end
    end

    assign dp_pu_a_o = term_q.pu_seg_a;
    assign dp_pu_b_o = term_q.pu_seg_b;
    assign dp_pd_o   = term_q.pd_dp;
    assign dm_pd_o   = term_q.pd_dm;

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        (dp_pu_a_o || dp_pu_b_o) |-> !(dp_pd_o || dm_pd_o)); // R5
    AST_HOST_TERMS: assert property (@(posedge clk) disable iff (rst)
        (applied_role == ROLE_HOST)
            |=> dp_pd_o && dm_pd_o && !dp_pu_a_o && !dp_pu_b_o); // R3
    AST_SESS_LOSS: assert property (@(posedge clk) disable iff (rst)
        !sess_s |=> !dp_pu_a_o && !dp_pu_b_o); // R8
    AST_SOFT_DISC: assert property (@(posedge clk) disable iff (rst)
        soft_disc_i |=> !dp_pu_a_o && !dp_pu_b_o); // R9
    AST_NO_ROLE_OFF: assert property (@(posedge clk) disable iff (rst)
        (applied_role == ROLE_NONE) |=> term_q == TERM_OFF); // R1
endmodule

// File: tb/usb_term_ctrl_tb.sv
module usb_term_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_W      = 4;
    localparam int SETTLE     = 4;
    localparam logic [3:0] HOST_T = 4'b0011;
    localparam logic [3:0] FULL_T = 4'b1100;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             role_valid = 1'b0;
    logic             role_host = 1'b0;
    logic             bsess = 1'b0;
    logic             soft_disc = 1'b0;
    logic [1:0]       strength = 2'b11;
    logic [GAP_W-1:0] gap = '0;
    logic             pu_a, pu_b, pd_dp, pd_dm;
    logic [3:0]       obs;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_term_ctrl #(.GAP_W(GAP_W), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .role_valid_i  (role_valid),
        .role_host_i   (role_host),
        .bsess_valid_i (bsess),
        .soft_disc_i   (soft_disc),
        .pu_strength_i (strength),
        .gap_cycles_i  (gap),
        .dp_pu_a_o     (pu_a),
        .dp_pu_b_o     (pu_b),
        .dp_pd_o       (pd_dp),
        .dm_pd_o       (pd_dm)
    );

    assign obs = {pu_a, pu_b, pd_dp, pd_dm};

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] pu_mask(input logic [1:0] s);
        return {s[0], s[1], 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int gaps[4] = '{0, 1, 2, 5};
        // R1: reset and no role
        repeat (3) tick();
        check("R1 reset", obs, 4'b0000);
        rst = 1'b0;
        bsess = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R1 no role", obs, 4'b0000);
        end

        // R4 R6 R7: gap and settle sweep in peripheral role
        foreach (gaps[gi]) begin
            for (int s = 0; s < 4; s++) begin
                gap = GAP_W'(gaps[gi]);
                strength = 2'(s);
                role_valid = 1'b1;
                role_host = 1'b0;
                for (int k = 1; k <= gaps[gi] + SETTLE + 5; k++) begin
                    tick();
                    if (k <= gaps[gi] + 2)
                        check("R4 gap off", obs, 4'b0000);
                    else if (k <= gaps[gi] + 2 + SETTLE)
                        check("R6 settle full", obs, FULL_T);
                    else
                        check("R7 strength", obs, pu_mask(2'(s)));
                end
                role_valid = 1'b0;
                for (int k = 1; k <= gaps[gi] + 3; k++) begin
                    tick();
                    if (k == 1)
                        check("R4 old role held", obs, pu_mask(2'(s)));
                    else
                        check("R4 release off", obs, 4'b0000);
                end
                tick();
            end
        end

        // R3: host role from no role
        gap = 4'd2;
        role_valid = 1'b1;
        role_host = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            tick();
            if (k <= 4) check("R4 host gap", obs, 4'b0000);
            else        check("R3 host terms", obs, HOST_T);
        end
        bsess = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R3 session ignored", obs, HOST_T);
        end
        soft_disc = 1'b1;
        for (int k = 0; k < 2; k++) begin
            tick();
            check("R3 soft disc ignored", obs, HOST_T);
        end
        soft_disc = 1'b0;
        bsess = 1'b1;
        repeat (4) tick();

        // R5 R4: host to peripheral switch
        gap = 4'd3;
        strength = 2'b10;
        role_host = 1'b0;
        for (int k = 1; k <= 3 + SETTLE + 4; k++) begin
            tick();
            if (k == 1)                check("R5 old host held", obs, HOST_T);
            else if (k <= 5)           check("R5 switch gap", obs, 4'b0000);
            else if (k <= 5 + SETTLE)  check("R6 settle after switch", obs, FULL_T);
            else                       check("R7 after switch", obs, pu_mask(2'b10));
        end

        // R7: strength codes while settled
        for (int s = 0; s < 4; s++) begin
            strength = 2'(s);
            tick();
            check("R7 live strength", obs, pu_mask(2'(s)));
        end

        // R8 R2: session loss and return
        strength = 2'b01;
        tick();
        bsess = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            tick();
            if (k <= 2) check("R8 sync latency", obs, pu_mask(2'b01));
            else        check("R2 R8 session lost", obs, 4'b0000);
        end
        bsess = 1'b1;
        for (int k = 1; k <= SETTLE + 4; k++) begin
            tick();
            if (k <= 2)               check("R8 return latency", obs, 4'b0000);
            else if (k <= SETTLE + 2) check("R6 settle on return", obs, FULL_T);
            else                      check("R7 after return", obs, pu_mask(2'b01));
        end

        // R9: soft disconnect
        soft_disc = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            tick();
            check("R9 soft disc off", obs, 4'b0000);
        end
        soft_disc = 1'b0;
        for (int k = 1; k <= SETTLE + 2; k++) begin
            tick();
            if (k <= SETTLE) check("R9 R6 resettle", obs, FULL_T);
            else             check("R9 after resettle", obs, pu_mask(2'b01));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule